// File: doc/BRIEF.md
# Audio Sample Unpacker for 64-bit FIFO Words

This block sits between a sample FIFO and a serial audio encoder. It takes 64-bit words from one of three upstream sources, cuts each word into equal right-justified sample lanes of 8, 16 or 32 bits, and left-aligns each sample to a signed 24-bit value. The position of the sample's top bit is programmable, so 20-bit or 24-bit data held in a wider lane is normalised correctly.

Samples are consumed as a mono stream or as left/right pairs. An optional mono sum averages the two channels. Each channel can then be scaled by its own 8-bit gain, or forced to zero. The serializer receives one left/right pair per valid/ready handshake. All configuration inputs are expected to stay constant while a word is partly consumed. The bench changes them only when the block is idle.

Top module: `audio_word_unpacker`

## Requirements
- R1: After reset, out_valid is 0, the word buffer is empty, and the source chosen by cfg_src sees in_ready high.
- R2: cfg_src values 0, 1 and 2 choose the upstream source with that index, and code 3 chooses none. Only the chosen source can ever see in_ready high. Data and valid from the other sources have no effect on the output.
- R3: A new word is accepted only while the buffer is empty. The buffer empties only after every lane of the held word has been consumed, so in_ready stays low on the cycle after a word is accepted.
- R4: cfg_type 0 gives eight 8-bit lanes, 2 gives four 16-bit lanes, and 4 gives two 32-bit lanes. Lane i occupies bits [i*w +: w], and lanes are used from i = 0 upward. For other codes, bit 2 selects 32-bit lanes, otherwise bit 1 selects 16-bit lanes, otherwise 8-bit lanes apply.
- R5: Lane bit cfg_msb lands on output bit 23. Lower output bits are zero-filled and lane bits above cfg_msb are dropped. When cfg_msb > 23, the lowest cfg_msb-23 lane bits are dropped. The output is read as two's complement.
- R6: With cfg_chmask bit 1 set (stereo, e.g. 0x3), lane i goes to the left channel and lane i+1 to the right channel. With bit 1 clear (mono, e.g. 0x1), each lane gives one pair that carries the sample on both channels. The other mask bits have no effect.
- R7: With cfg_mix set, both channels carry floor((L+R)/2), computed before gain.
- R8: With cfg_gain_en set, each channel becomes floor(s*g/256), where g is that channel's gain. With it clear, the gain values have no effect.
- R9: A muted channel outputs 0 whatever the gain and mix settings.
- R10: A pair transfers when out_valid and out_ready are both high. While out_valid is high and out_ready is low, the pair holds steady. Within a word, one pair can leave every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 2 | Upstream source select (3 = none) |
| cfg_type | input | 3 | Lane packing code |
| cfg_msb | input | 5 | Bit index of the sample's top bit within its lane |
| cfg_chmask | input | 8 | Channel mask; bit 1 selects stereo |
| cfg_mix | input | 1 | Average both channels |
| cfg_gain_en | input | 1 | Apply per-channel gain |
| cfg_gain_l | input | 8 | Left gain, unit = 1/256 |
| cfg_gain_r | input | 8 | Right gain, unit = 1/256 |
| cfg_mute_l | input | 1 | Force left output to zero |
| cfg_mute_r | input | 1 | Force right output to zero |
| in_data | input | 192 | Three 64-bit source words, source k at [64k +: 64] |
| in_valid | input | 3 | Per-source word valid |
| in_ready | output | 3 | Per-source word ready |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Serializer accepts pair |
| out_left | output | 24 | Left sample, signed, left-aligned |
| out_right | output | 24 | Right sample, signed, left-aligned |

## Verification
Two things can happen in the same cycle. The last lane of a word can be consumed while the serializer retires the previous pair, and a fresh word can be loaded while the output register is stalled by backpressure. The bench provokes both by dropping out_ready at random during sweeps over every packing code, several MSB positions, mono and stereo, mix, and several gain and mute settings. It judges them by comparing every transferred pair, in order, against a queue of pairs computed arithmetically from each accepted word. A lost, repeated or reordered lane therefore shows up as a miscompare.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

  // Lane width in bits for a packing code: bit 2 -> 32, bit 1 -> 16, else 8
  function automatic logic [5:0] lane_bits(input logic [2:0] code);
    if (code[2])      return 6'd32;
    else if (code[1]) return 6'd16;
    else              return 6'd8;
  endfunction

endpackage

// File: rtl/unpack_word_buf.sv
// Source select plus holding register for one FIFO word and its lane cursor
module unpack_word_buf #(
  parameter int WORD_W = 64,
  parameter int NSRC   = 3,
  parameter int SEL_W  = 2,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_W-1:0]       src_sel,
  input  logic [NSRC*WORD_W-1:0] src_data,
  input  logic [NSRC-1:0]        src_valid,
  output logic [NSRC-1:0]        src_ready,
  input  logic                   take,
  input  logic [1:0]             step,
  input  logic [IDX_W:0]         nslots,
  output logic                   have,
  output logic [WORD_W-1:0]      word,
  output logic [IDX_W-1:0]       slot
);

  logic              have_q, have_d;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  slot_q, slot_d;
  logic              sel_valid;
  logic [WORD_W-1:0] sel_word;
  logic              load;
  logic [IDX_W+1:0]  nxt;

  for (genvar s = 0; s < NSRC; s++) begin : g_ready
    assign src_ready[s] = !have_q && (src_sel == SEL_W'(s));
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_word  = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_sel == SEL_W'(s)) begin
        sel_valid = src_valid[s];
        sel_word  = src_data[s*WORD_W +: WORD_W];
      end
    end
  end

  assign load = !have_q && sel_valid;
  assign nxt  = {2'b00, slot_q} + {{IDX_W{1'b0}}, step};

  always_comb begin
    have_d = have_q;
    slot_d = slot_q;
    if (load) begin
      have_d = 1'b1;
      slot_d = '0;
    end else if (take) begin
      if (nxt >= {1'b0, nslots}) begin
        have_d = 1'b0;
        slot_d = '0;
      end else begin
        slot_d = nxt[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      slot_q <= '0;
    end else begin
      have_q <= have_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= sel_word;
  end

  assign have = have_q;
  assign word = word_q;
  assign slot = slot_q;

endmodule

// File: rtl/unpack_lane_align.sv
// Extracts one right-justified lane and moves its MSB to the top of the output
module unpack_lane_align #(
  parameter int WORD_W = 64,
  parameter int LANE_W = 32,
  parameter int OUT_W  = 24,
  parameter int IDX_W  = 3,
  parameter int MSB_W  = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic [5:0]        lane_w,
  input  logic [MSB_W-1:0]  msb,
  output logic [OUT_W-1:0]  smp
);

  localparam logic [MSB_W-1:0] TOP = MSB_W'(LANE_W - 1);

  logic [WORD_W-1:0] shifted;
  logic [LANE_W-1:0] lmask;
  logic [LANE_W-1:0] raw;
  logic [LANE_W-1:0] up;
  logic [8:0]        sh;

  always_comb begin
    sh      = 9'(idx) * 9'(lane_w);
    shifted = word >> sh;
    if (32'(lane_w) >= LANE_W) lmask = '1;
    else                       lmask = (LANE_W'(1) << lane_w) - LANE_W'(1);
    raw     = shifted[LANE_W-1:0] & lmask;
    up      = raw << (TOP - msb);
    smp     = up[LANE_W-1 -: OUT_W];
  end

endmodule

// File: rtl/unpack_chan_gain.sv
// Per-channel scale by gain/256 (floor) and mute
module unpack_chan_gain #(
  parameter int OUT_W  = 24,
  parameter int GAIN_W = 8
) (
  input  logic [OUT_W-1:0]  din,
  input  logic [GAIN_W-1:0] gain,
  input  logic              gain_en,
  input  logic              mute,
  output logic [OUT_W-1:0]  dout
);

  localparam int PROD_W = OUT_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  always_comb begin
    prod   = $signed(din) * $signed({1'b0, gain});
    scaled = prod >>> GAIN_W;
    if (mute)         dout = '0;
    else if (gain_en) dout = scaled[OUT_W-1:0];
    else              dout = din;
  end

endmodule

// File: rtl/audio_word_unpacker.sv
module audio_word_unpacker #(
  parameter int WORD_W = 64,
  parameter int NSRC   = 3,
  parameter int SEL_W  = 2,
  parameter int OUT_W  = 24,
  parameter int GAIN_W = 8,
  parameter int MASK_W = 8,
  parameter int LANE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_W-1:0]       cfg_src,
  input  logic [2:0]             cfg_type,
  input  logic [$clog2(LANE_W)-1:0] cfg_msb,
  input  logic [MASK_W-1:0]      cfg_chmask,
  input  logic                   cfg_mix,
  input  logic                   cfg_gain_en,
  input  logic [GAIN_W-1:0]      cfg_gain_l,
  input  logic [GAIN_W-1:0]      cfg_gain_r,
  input  logic                   cfg_mute_l,
  input  logic                   cfg_mute_r,
  input  logic [NSRC*WORD_W-1:0] in_data,
  input  logic [NSRC-1:0]        in_valid,
  output logic [NSRC-1:0]        in_ready,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_left,
  output logic [OUT_W-1:0]       out_right
);
  import unpack_pkg::*;

  localparam int MSB_W = $clog2(LANE_W);
  localparam int IDX_W = $clog2(WORD_W / 8);
  localparam int NCH   = 2;

  logic              buf_have;
  logic [WORD_W-1:0] buf_word;
  logic [IDX_W-1:0]  buf_slot;
  logic              stereo;
  logic [1:0]        step;
  logic [5:0]        lw;
  logic [IDX_W:0]    nslots;
  logic              adv;

  logic [IDX_W-1:0]  lane_idx [NCH];
  logic [OUT_W-1:0]  lane_smp [NCH];
  logic [OUT_W-1:0]  mix_smp  [NCH];
  logic [OUT_W-1:0]  fin_smp  [NCH];
  logic [GAIN_W-1:0] ch_gain  [NCH];
  logic              ch_mute  [NCH];
  logic signed [OUT_W:0] msum;

  logic              ov_q, ov_d;
  logic [OUT_W-1:0]  ol_q, or_q;

  assign stereo = cfg_chmask[1];
  assign step   = stereo ? 2'd2 : 2'd1;
  assign lw     = lane_bits(cfg_type);

  always_comb begin
    if (cfg_type[2])      nslots = (IDX_W+1)'(WORD_W / 32);
    else if (cfg_type[1]) nslots = (IDX_W+1)'(WORD_W / 16);
    else                  nslots = (IDX_W+1)'(WORD_W / 8);
  end

  assign adv = buf_have && (!ov_q || out_ready);

  unpack_word_buf #(
    .WORD_W(WORD_W), .NSRC(NSRC), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) i_buf (
    .clk(clk), .rst_n(rst_n), .src_sel(cfg_src), .src_data(in_data),
    .src_valid(in_valid), .src_ready(in_ready), .take(adv), .step(step),
    .nslots(nslots), .have(buf_have), .word(buf_word), .slot(buf_slot)
  );

  assign lane_idx[0] = buf_slot;
  assign lane_idx[1] = stereo ? buf_slot + IDX_W'(1) : buf_slot;
  assign ch_gain[0]  = cfg_gain_l;
  assign ch_gain[1]  = cfg_gain_r;
  assign ch_mute[0]  = cfg_mute_l;
  assign ch_mute[1]  = cfg_mute_r;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    unpack_lane_align #(
      .WORD_W(WORD_W), .LANE_W(LANE_W), .OUT_W(OUT_W), .IDX_W(IDX_W), .MSB_W(MSB_W)
    ) i_align (
      .word(buf_word), .idx(lane_idx[c]), .lane_w(lw), .msb(cfg_msb), .smp(lane_smp[c])
    );
  end

  // mono sum: floor of the average, taken from the sum's upper bits
  assign msum = $signed({lane_smp[0][OUT_W-1], lane_smp[0]})
              + $signed({lane_smp[1][OUT_W-1], lane_smp[1]});

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign mix_smp[c] = cfg_mix ? msum[OUT_W:1] : lane_smp[c];
    unpack_chan_gain #(.OUT_W(OUT_W), .GAIN_W(GAIN_W)) i_gain (
      .din(mix_smp[c]), .gain(ch_gain[c]), .gain_en(cfg_gain_en),
      .mute(ch_mute[c]), .dout(fin_smp[c])
    );
  end

  always_comb begin
    ov_d = ov_q;
    if (adv)            ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ol_q <= '0;
      or_q <= '0;
    end else if (adv) begin
      ol_q <= fin_smp[0];
      or_q <= fin_smp[1];
    end
  end

  assign out_valid = ov_q;
  assign out_left  = ol_q;
  assign out_right = or_q;

endmodule

// File: rtl/unpack_checker.sv
module unpack_checker #(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2,
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] cfg_src,
  input logic             cfg_mute_l,
  input logic             cfg_mute_r,
  input logic [NSRC-1:0]  in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_left,
  input logic [OUT_W-1:0] out_right,
  input logic             buf_have
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  // R2
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  // R2
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src == SEL_W'(NSRC)) |-> (in_ready == '0));

  // R3
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> !buf_have);

  // R3
  pair_from_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(buf_have));

  // R9
  mute_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && $past(cfg_mute_l)) |-> (out_left == '0));

  // R9
  mute_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && $past(cfg_mute_r)) |-> (out_right == '0));

endmodule

bind audio_word_unpacker unpack_checker #(
  .NSRC(NSRC), .SEL_W(SEL_W), .OUT_W(OUT_W)
) i_unpack_checker (
  .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_mute_l(cfg_mute_l),
  .cfg_mute_r(cfg_mute_r), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
  .buf_have(buf_have)
);

// File: tb/test_audio_word_unpacker.sv
`timescale 1ns/1ps
module test_audio_word_unpacker;

  logic         clk;
  logic         rst_n;
  logic [1:0]   cfg_src;
  logic [2:0]   cfg_type;
  logic [4:0]   cfg_msb;
  logic [7:0]   cfg_chmask;
  logic         cfg_mix, cfg_gain_en, cfg_mute_l, cfg_mute_r;
  logic [7:0]   cfg_gain_l, cfg_gain_r;
  logic [191:0] in_data;
  logic [2:0]   in_valid, in_ready;
  logic         out_valid, out_ready;
  logic [23:0]  out_left, out_right;

  int n_chk = 0;
  int n_bad = 0;
  int exp_l[$];
  int exp_r[$];

  audio_word_unpacker i_audio_word_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_type(cfg_type),
    .cfg_msb(cfg_msb), .cfg_chmask(cfg_chmask), .cfg_mix(cfg_mix),
    .cfg_gain_en(cfg_gain_en), .cfg_gain_l(cfg_gain_l), .cfg_gain_r(cfg_gain_r),
    .cfg_mute_l(cfg_mute_l), .cfg_mute_r(cfg_mute_r), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int lane_w(input logic [2:0] code);
    return code[2] ? 32 : (code[1] ? 16 : 8);
  endfunction

  // R4/R5: lane i at [i*w +: w], bit msb moved to bit 23, two's complement
  function automatic int model_lane(input logic [63:0] w64, input int i, input int w, input int m);
    logic [63:0] x;
    logic [31:0] t;
    logic [23:0] top;
    x   = w64 >> (i * w);
    if (w < 64) x = x & ((64'd1 << w) - 64'd1);
    t   = x[31:0] << (31 - m);
    top = t[31:8];
    return int'($signed(top));
  endfunction

  function automatic void push_word(input logic [63:0] w64);
    int w, n, stp, a, b, mm;
    w   = lane_w(cfg_type);
    n   = 64 / w;
    stp = cfg_chmask[1] ? 2 : 1;
    for (int i = 0; i < n; i += stp) begin
      a = model_lane(w64, i, w, int'(cfg_msb));
      b = cfg_chmask[1] ? model_lane(w64, i + 1, w, int'(cfg_msb)) : a;  // R6
      if (cfg_mix) begin mm = (a + b) >>> 1; a = mm; b = mm; end         // R7
      if (cfg_gain_en) begin                                             // R8
        a = (a * int'(cfg_gain_l)) >>> 8;
        b = (b * int'(cfg_gain_r)) >>> 8;
      end
      if (cfg_mute_l) a = 0;                                              // R9
      if (cfg_mute_r) b = 0;
      exp_l.push_back(a);
      exp_r.push_back(b);
    end
  endfunction

  function automatic string tag_now();
    if (cfg_mute_l || cfg_mute_r) return "R9";
    if (cfg_gain_en)              return "R8";
    if (cfg_mix)                  return "R7";
    if (cfg_chmask[1])            return "R6";
    return "R5";
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Feed nwords to the selected source with random backpressure (R10)
  task automatic run_words(input int nwords);
    int sent = 0, stray = 0, early = 0, el, er;
    logic fire, prev_fire = 1'b0;
    string tg;
    tg = tag_now();
    in_data[int'(cfg_src)*64 +: 64] = rnd64();
    in_valid[cfg_src] = 1'b1;
    while (sent < nwords || exp_l.size() != 0) begin
      @(negedge clk);
      if (out_valid && out_ready) begin
        if (exp_l.size() == 0) begin
          check("R10", 1, 0);
        end else begin
          el = exp_l.pop_front();
          er = exp_r.pop_front();
          check(tg, int'($signed(out_left)), el);
          check(tg, int'($signed(out_right)), er);
        end
      end
      for (int s = 0; s < 3; s++)
        if (s != int'(cfg_src) && in_ready[s]) stray++;
      if (prev_fire && in_ready[cfg_src]) early++;
      fire = in_valid[cfg_src] && in_ready[cfg_src];
      if (fire) begin
        push_word(in_data[int'(cfg_src)*64 +: 64]);
        sent++;
      end
      prev_fire = fire;
      @(posedge clk);
      #0.5;
      if (fire) begin
        if (sent < nwords) in_data[int'(cfg_src)*64 +: 64] = rnd64();
        else               in_valid[cfg_src] = 1'b0;
      end
      out_ready = ($urandom() % 4) != 0;
    end
    check("R2", stray, 0);
    check("R3", early, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int msb_list[3][4];
    int msb_cnt[3];
    int run = 0;
    msb_list[0] = '{7, 3, 0, 0};    msb_cnt[0] = 2;
    msb_list[1] = '{15, 11, 0, 0};  msb_cnt[1] = 2;
    msb_list[2] = '{23, 19, 31, 15}; msb_cnt[2] = 4;

    rst_n = 1'b0; cfg_src = 2'd0; cfg_type = 3'd0; cfg_msb = 5'd7;
    cfg_chmask = 8'h01; cfg_mix = 1'b0; cfg_gain_en = 1'b0;
    cfg_gain_l = 8'd0; cfg_gain_r = 8'd0; cfg_mute_l = 1'b0; cfg_mute_r = 1'b0;
    in_data = '0; in_valid = 3'b000; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset, selected source ready
    check("R1", int'(out_valid), 0);
    check("R1", int'(in_ready), 1);

    // R2: code 3 selects no source; other sources stay ignored
    @(posedge clk); #0.5;
    cfg_src = 2'd3;
    in_valid = 3'b111;
    in_data = {rnd64(), rnd64(), rnd64()};
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R2", int'(in_ready), 0);
      check("R2", int'(out_valid), 0);
    end
    @(posedge clk); #0.5;
    in_valid = 3'b000;

    for (int t = 0; t < 3; t++) begin
      for (int mi = 0; mi < msb_cnt[t]; mi++) begin
        for (int st = 0; st < 2; st++) begin
          for (int mx = 0; mx < 2; mx++) begin
            for (int gv = 0; gv < 4; gv++) begin
              @(posedge clk); #0.5;
              cfg_src    = 2'(run % 3);
              in_valid   = 3'b111;          // other sources valid: must be ignored
              in_data    = {rnd64(), rnd64(), rnd64()};
              cfg_type   = 3'(2 * t);      // R4: codes 0, 2, 4
              cfg_msb    = 5'(msb_list[t][mi]);
              cfg_chmask = st ? 8'h03 : 8'h01;
              cfg_mix    = 1'(mx);
              cfg_gain_l = 8'($urandom());
              cfg_gain_r = 8'($urandom());
              cfg_gain_en = 1'b0; cfg_mute_l = 1'b0; cfg_mute_r = 1'b0;
              case (gv)
                1: begin cfg_gain_en = 1'b1; cfg_gain_r = 8'd255; end
                2: begin cfg_gain_en = 1'b1; cfg_gain_l = 8'h80; cfg_mute_r = 1'b1; end
                3: cfg_mute_l = 1'b1;
                default: ;
              endcase
              in_valid[cfg_src] = 1'b0;
              run_words(4);
              in_valid = 3'b000;
              run++;
            end
          end
        end
      end
    end

    // R4: non-listed codes 1 (8-bit) and 7 (32-bit)
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #0.5;
      cfg_src = 2'd1; cfg_type = k ? 3'd7 : 3'd1; cfg_msb = k ? 5'd23 : 5'd7;
      cfg_chmask = 8'hFF; cfg_mix = 1'b0; cfg_gain_en = 1'b0;
      cfg_mute_l = 1'b0; cfg_mute_r = 1'b0;
      run_words(3);
      in_valid = 3'b000;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule